// File: doc/BRIEF.md
# Borrowed-bus memory cycle master

This block lets a host-side controller reach into the memory space of an 8-bit CPU system by temporarily taking that system's bus. It asks for the bus on an active-low request line and waits for the CPU to confirm on an active-low acknowledge line. Only after that confirmation does it turn on its address drivers. While it owns the bus it runs single-byte memory writes and reads. Each cycle drives a 19-bit address, an active-low memory-enable strobe, active-low read and write strobes, and an 8-bit data bus whose direction is set by an output-enable. When the host lets go, the block first turns the data bus back to input and then tri-states the address drivers. Last, it lifts the request line and waits for the acknowledge to go inactive.

The host side has an acquire pulse, a release pulse and one command port. The command port carries write/read select, a chain flag, an address and write data, and returns read data, a busy level and a one-cycle done pulse. A chained command leaves memory-enable low at its end, so a run of bytes can be written under a single memory-enable window with one write pulse per byte. A command given while the bus is not owned is refused with a one-cycle error pulse and causes no bus activity.

Top module: `bus_borrow_master`

## Requirements
- R1: After reset, bus_req_n, me_n, rd_n, wr_n and nmi_n are 1; data_oe, addr_oe, owned, busy, done and err are 0. nmi_n stays at 1 at all times.
- R2: An acq_req pulse in the idle state drives bus_req_n to 0 on the next cycle. addr_oe and owned stay 0 until bus_ack_n is sampled 0, and both become 1 in the cycle after that sample.
- R3: An accepted write drives addr_o, sets me_n to 0 and drives data_o with data_oe set to 1. One cycle later wr_n goes to 0 for WR_LOW cycles (default 1) and then returns to 1. Whenever wr_n is 0, data_oe is 1 and me_n is 0.
- R4: An accepted read sets me_n to 0 and data_oe to 0. One cycle later rd_n goes to 0 for RD_LOW cycles (default 2). data_i is captured into rdata at the last clock edge at which rd_n is still 0, and rdata holds that value until the next read.
- R5: An rel_req pulse while owned and not busy sets data_oe to 0 and me_n to 1, and owned falls, all on the next cycle. addr_oe goes to 0 one cycle later, and bus_req_n goes to 1 one cycle after that. The block then returns to idle once bus_ack_n is sampled 1.
- R6: A write completes with done asserted WR_LOW+2 cycles after the accept edge, and a read completes RD_LOW+2 cycles after it. A non-chained command sets me_n back to 1 at the same edge that asserts done.
- R7: cmd_valid while not owned (idle, acquiring or releasing) produces a one-cycle err pulse on the next cycle. It produces no strobe and leaves me_n at 1.
- R8: busy is 1 from the cycle after the accept edge until done. done is a one-cycle pulse, and busy is 0 when done is 1.
- R9: A command with cmd_chain=1 leaves me_n at 0 after its done. A chained write also keeps data_oe at 1. Successive chained writes therefore pulse wr_n once per byte without me_n rising, and me_n rises only at the end of the first non-chained command.
- R10: cmd_valid during a busy cycle is ignored: it causes no extra strobe and no write to its address. When cmd_valid and rel_req arrive together while owned, the command is taken and the release is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | 1 | Pulse: start taking the bus |
| rel_req | input | 1 | Pulse: give the bus back |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_chain | input | 1 | 1 = keep memory-enable low after this command |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Write data |
| bus_ack_n | input | 1 | Bus acknowledge from the CPU, active low |
| data_i | input | DW | Data bus input from the memory side |
| bus_req_n | output | 1 | Bus request to the CPU, active low |
| addr_o | output | AW | Address bus value |
| addr_oe | output | 1 | Address driver enable |
| me_n | output | 1 | Memory-enable strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| nmi_n | output | 1 | Non-maskable interrupt line, held inactive |
| data_o | output | DW | Data bus value driven on writes |
| data_oe | output | 1 | Data driver enable |
| rdata | output | DW | Last byte read |
| owned | output | 1 | Bus held and ready for commands |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle command completion pulse |
| err | output | 1 | One-cycle refusal pulse for an unowned command |

## Verification
The hardest windows to reach are the two waiting states: the CPU holding off acknowledge after a request, and holding acknowledge low after the request is lifted. The bench drives bus_ack_n by hand and holds it for several cycles in each case. It issues commands inside both windows to show they are refused while the address drivers stay off. A second hard case is a command arriving in the middle of a busy cycle, or at the same edge as a release. The bench puts these inputs into exact cycles of a running write. It then confirms the result through the strobe count, the ownership output and a later read of the address the ignored command named.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ACQ, S_OWN,
    S_WSTB, S_WHOLD, S_WFIN,
    S_RSTB, S_RHOLD, S_RFIN,
    S_RELA, S_RELB, S_RELW
  } bbm_state_e;

  function automatic logic st_busy(input bbm_state_e s);
    return (s == S_WSTB) || (s == S_WHOLD) || (s == S_WFIN) ||
           (s == S_RSTB) || (s == S_RHOLD) || (s == S_RFIN);
  endfunction

  function automatic logic st_owned(input bbm_state_e s);
    return (s == S_OWN) || st_busy(s);
  endfunction

  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/bbm_strobe_timer.sv
module bbm_strobe_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= len - CW'(1);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
  import bbm_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 8,
  parameter int WR_LOW = 1,
  parameter int RD_LOW = 2,
  parameter int CW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_req,
  input  logic          rel_req,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic          cmd_chain,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          bus_ack_n,
  input  logic [DW-1:0] data_i,
  input  logic          strobe_end,
  output logic          timer_load,
  output logic [CW-1:0] timer_len,
  output logic          cmd_accept,
  output logic          cmd_reject,
  output logic          bus_req_n,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe,
  output logic          me_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic [DW-1:0] rdata,
  output logic          owned,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [CW-1:0] WR_LEN = CW'(WR_LOW);
  localparam logic [CW-1:0] RD_LEN = CW'(RD_LOW);

  bbm_state_e state;
  logic       chain_q;

  assign owned      = st_owned(state);
  assign busy       = st_busy(state);
  assign cmd_accept = cmd_valid && (state == S_OWN);
  assign cmd_reject = cmd_valid && !owned;
  assign timer_load = (state == S_WSTB) || (state == S_RSTB);
  assign timer_len  = (state == S_WSTB) ? WR_LEN : RD_LEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bus_req_n <= 1'b1;
      addr_oe   <= 1'b0;
      addr_o    <= '0;
      me_n      <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      data_o    <= '0;
      data_oe   <= 1'b0;
      rdata     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      chain_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= cmd_reject;
      case (state)
        S_IDLE: if (acq_req) begin
          bus_req_n <= 1'b0;
          state     <= S_ACQ;
        end
        S_ACQ: if (!bus_ack_n) begin
          addr_oe <= 1'b1;
          state   <= S_OWN;
        end
        S_OWN: begin
          if (cmd_accept) begin
            addr_o  <= cmd_addr;
            chain_q <= cmd_chain;
            me_n    <= 1'b0;
            if (cmd_write) begin
              data_o  <= cmd_wdata;
              data_oe <= 1'b1;
              state   <= S_WSTB;
            end else begin
              data_oe <= 1'b0;
              state   <= S_RSTB;
            end
          end else if (rel_req) begin
            data_oe <= 1'b0;
            me_n    <= 1'b1;
            state   <= S_RELA;
          end
        end
        S_WSTB: begin
          wr_n  <= 1'b0;
          state <= S_WHOLD;
        end
        S_WHOLD: if (strobe_end) begin
          wr_n  <= 1'b1;
          state <= S_WFIN;
        end
        S_WFIN: begin
          me_n    <= ~chain_q;
          data_oe <= chain_q;
          done    <= 1'b1;
          state   <= S_OWN;
        end
        S_RSTB: begin
          rd_n  <= 1'b0;
          state <= S_RHOLD;
        end
        S_RHOLD: if (strobe_end) begin
          rdata <= data_i;
          rd_n  <= 1'b1;
          state <= S_RFIN;
        end
        S_RFIN: begin
          me_n  <= ~chain_q;
          done  <= 1'b1;
          state <= S_OWN;
        end
        S_RELA: begin
          addr_oe <= 1'b0;
          state   <= S_RELB;
        end
        S_RELB: begin
          bus_req_n <= 1'b1;
          state     <= S_RELW;
        end
        S_RELW: if (bus_ack_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_borrow_master.sv
module bus_borrow_master
  import bbm_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 8,
  parameter int WR_LOW = 1,
  parameter int RD_LOW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_req,
  input  logic          rel_req,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic          cmd_chain,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          bus_ack_n,
  input  logic [DW-1:0] data_i,
  output logic          bus_req_n,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe,
  output logic          me_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          nmi_n,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic [DW-1:0] rdata,
  output logic          owned,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int CW = cnt_width(WR_LOW + 1, RD_LOW + 1);

  logic          strobe_end;
  logic          timer_load;
  logic [CW-1:0] timer_len;
  logic          cmd_accept;
  logic          cmd_reject;

  assign nmi_n = 1'b1;

  bbm_strobe_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .len(timer_len),
    .expired(strobe_end)
  );

  bbm_seq #(.AW(AW), .DW(DW), .WR_LOW(WR_LOW), .RD_LOW(RD_LOW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_chain(cmd_chain),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .bus_ack_n(bus_ack_n),
    .data_i(data_i), .strobe_end(strobe_end), .timer_load(timer_load),
    .timer_len(timer_len), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .bus_req_n(bus_req_n), .addr_o(addr_o), .addr_oe(addr_oe), .me_n(me_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_o(data_o), .data_oe(data_oe),
    .rdata(rdata), .owned(owned), .busy(busy), .done(done), .err(err)
  );
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_ack_n,
  input logic bus_req_n,
  input logic addr_oe,
  input logic me_n,
  input logic rd_n,
  input logic wr_n,
  input logic data_oe,
  input logic done,
  input logic err,
  input logic busy,
  input logic cmd_accept,
  input logic cmd_reject
);
  a_r2_addr_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> !$past(bus_ack_n));

  a_r5_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_n) |-> (!addr_oe && !data_oe));

  a_r3_write_drives_data: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (data_oe && !me_n));

  a_r4_read_bus_input: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!data_oe && !me_n));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);

  a_r7_reject_err: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> (err && me_n && rd_n && wr_n));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n));
endmodule

bind bus_borrow_master bbm_checker u_bbm_checker (
  .clk(clk), .rst_n(rst_n), .bus_ack_n(bus_ack_n), .bus_req_n(bus_req_n),
  .addr_oe(addr_oe), .me_n(me_n), .rd_n(rd_n), .wr_n(wr_n),
  .data_oe(data_oe), .done(done), .err(err), .busy(busy),
  .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
);

// File: tb/tb_bus_borrow_master.sv
`timescale 1ns/1ps
module tb_bus_borrow_master;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int WR_LOW = 1;
  localparam int RD_LOW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_req = 0, rel_req = 0, cmd_valid = 0, cmd_write = 0, cmd_chain = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic bus_ack_n = 1'b1;
  logic [DW-1:0] data_i;
  logic bus_req_n, addr_oe, me_n, rd_n, wr_n, nmi_n, data_oe, owned, busy, done, err;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o, rdata;

  always #2 clk = ~clk;

  bus_borrow_master #(.AW(AW), .DW(DW), .WR_LOW(WR_LOW), .RD_LOW(RD_LOW)) dut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_chain(cmd_chain),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .bus_ack_n(bus_ack_n),
    .data_i(data_i), .bus_req_n(bus_req_n), .addr_o(addr_o), .addr_oe(addr_oe),
    .me_n(me_n), .rd_n(rd_n), .wr_n(wr_n), .nmi_n(nmi_n), .data_o(data_o),
    .data_oe(data_oe), .rdata(rdata), .owned(owned), .busy(busy), .done(done),
    .err(err)
  );

  int n_run = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model and strobe monitor, sampled 1 ns after each rising edge
  logic [7:0] mem [256];
  logic prev_wr = 1'b1, prev_rd = 1'b1, prev_me = 1'b1;
  int wr_pulses = 0, me_rises = 0, viol = 0, rd_run = 0, rd_len = 0;
  logic [AW-1:0] last_wa = '0;
  logic [DW-1:0] last_wd = '0;

  assign data_i = rd_n ? 8'h00 : mem[addr_o[7:0]];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    #1;
    if (!wr_n && (!data_oe || me_n)) viol++;
    if (!rd_n && (data_oe || me_n)) viol++;
    if (wr_n && !prev_wr) begin
      wr_pulses++;
      mem[addr_o[7:0]] = data_o;
      last_wa = addr_o;
      last_wd = data_o;
    end
    if (!rd_n) rd_run++;
    if (rd_n && !prev_rd) begin rd_len = rd_run; rd_run = 0; end
    if (me_n && !prev_me) me_rises++;
    prev_wr = wr_n; prev_rd = rd_n; prev_me = me_n;
  end

  function automatic logic [AW-1:0] addr_of(input int i);
    logic [10:0] hi;
    hi = 11'((i * 13 + 7) & 11'h7FF);
    return {hi, 8'(i)};
  endfunction

  function automatic logic [7:0] data_of(input int i);
    return 8'((i * 37 + 91) & 8'hFF);
  endfunction

  task automatic do_cmd(input bit w, input bit ch, input bit also_rel,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat;
    @(negedge clk);
    cmd_valid = 1; cmd_write = w; cmd_chain = ch; cmd_addr = a; cmd_wdata = d;
    rel_req = also_rel;
    @(negedge clk);
    cmd_valid = 0; rel_req = 0;
    lat = 1;
    check(busy === 1'b1, "R8", "busy after accept", busy, 1);
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    check(lat - 1 == (w ? WR_LOW : RD_LOW) + 2, "R6", "done latency", lat - 1,
          (w ? WR_LOW : RD_LOW) + 2);
    check(busy === 1'b0, "R8", "busy low at done", busy, 0);
    @(negedge clk);
    check(done === 1'b0, "R8", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int pulses0, rises0;
    repeat (3) @(negedge clk);
    check({bus_req_n, me_n, rd_n, wr_n, nmi_n} === 5'b11111, "R1", "strobes in reset",
          {bus_req_n, me_n, rd_n, wr_n, nmi_n}, 5'b11111);
    rst_n = 1'b1;
    @(negedge clk);
    check({data_oe, addr_oe, owned, busy, done, err} === 6'b0, "R1", "idle outputs",
          {data_oe, addr_oe, owned, busy, done, err}, 0);
    check({bus_req_n, me_n, rd_n, wr_n, nmi_n} === 5'b11111, "R1", "idle strobes",
          {bus_req_n, me_n, rd_n, wr_n, nmi_n}, 5'b11111);

    // R7: command while idle
    cmd_valid = 1; cmd_write = 1; cmd_addr = 19'h00011; cmd_wdata = 8'h55;
    @(negedge clk); cmd_valid = 0;
    check(err === 1'b1, "R7", "err on idle cmd", err, 1);
    check(me_n === 1'b1, "R7", "me_n stays high", me_n, 1);
    @(negedge clk);
    check(err === 1'b0, "R7", "err one cycle", err, 0);
    check(wr_pulses == 0, "R7", "no write strobe", wr_pulses, 0);

    // R2: acquire with delayed acknowledge
    acq_req = 1; @(negedge clk); acq_req = 0;
    check(bus_req_n === 1'b0, "R2", "request driven", bus_req_n, 0);
    cmd_valid = 1; cmd_write = 0; @(negedge clk); cmd_valid = 0;
    check(err === 1'b1, "R7", "err while acquiring", err, 1);
    repeat (4) @(negedge clk);
    check(addr_oe === 1'b0 && owned === 1'b0, "R2", "no drive before ack",
          {addr_oe, owned}, 0);
    bus_ack_n = 0;
    @(negedge clk);
    check(addr_oe === 1'b1 && owned === 1'b1, "R2", "drive after ack",
          {addr_oe, owned}, 2'b11);
    check(rd_n === 1'b1 && wr_n === 1'b1, "R4", "no strobe from acquire", {rd_n, wr_n}, 2'b11);

    // R3: write sweep over every low address byte
    for (int i = 0; i < 256; i++) begin
      do_cmd(1'b1, 1'b0, 1'b0, addr_of(i), data_of(i));
      check(last_wa === addr_of(i), "R3", "write address", last_wa, addr_of(i));
      check(last_wd === data_of(i), "R3", "write data", last_wd, data_of(i));
      check(me_n === 1'b1 && data_oe === 1'b0, "R6", "me_n high after write",
            {me_n, data_oe}, 2'b10);
    end
    check(wr_pulses == 256, "R3", "one pulse per write", wr_pulses, 256);

    // R10: command during busy is ignored
    pulses0 = wr_pulses;
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_chain = 0; cmd_addr = addr_of(3); cmd_wdata = data_of(3);
    @(negedge clk);
    cmd_addr = addr_of(8'hF0); cmd_wdata = ~data_of(8'hF0);
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(wr_pulses - pulses0 == 1, "R10", "ignored cmd strobes", wr_pulses - pulses0, 1);

    // R10: command wins over simultaneous release
    do_cmd(1'b0, 1'b0, 1'b1, addr_of(5), 8'h00);
    check(owned === 1'b1 && addr_oe === 1'b1, "R10", "release dropped", {owned, addr_oe}, 2'b11);

    // R4: read sweep
    for (int i = 0; i < 256; i++) begin
      do_cmd(1'b0, 1'b0, 1'b0, addr_of(i), 8'h00);
      check(rdata === data_of(i), "R4", "read data", rdata, data_of(i));
      check(rd_len == RD_LOW, "R4", "read strobe length", rd_len, RD_LOW);
    end

    // R9: chained block write
    rises0 = me_rises;
    for (int k = 0; k < 4; k++) begin
      do_cmd(1'b1, (k != 3), 1'b0, addr_of(8'h40 + k), ~data_of(8'h40 + k));
      @(negedge clk);
      if (k != 3)
        check(me_n === 1'b0 && data_oe === 1'b1, "R9", "me held low in chain",
              {me_n, data_oe}, 2'b01);
    end
    check(me_rises - rises0 == 1, "R9", "single me_n rise", me_rises - rises0, 1);
    for (int k = 0; k < 4; k++) begin
      do_cmd(1'b0, 1'b0, 1'b0, addr_of(8'h40 + k), 8'h00);
      check(rdata === ~data_of(8'h40 + k), "R9", "chained byte", rdata, ~data_of(8'h40 + k));
    end
    check(viol == 0, "R3", "strobe ordering", viol, 0);

    // R5: release sequence
    @(negedge clk);
    rel_req = 1; @(negedge clk); rel_req = 0;
    check(data_oe === 1'b0 && me_n === 1'b1 && owned === 1'b0 && addr_oe === 1'b1,
          "R5", "step one", {data_oe, me_n, owned, addr_oe}, 4'b0101);
    @(negedge clk);
    check(addr_oe === 1'b0 && bus_req_n === 1'b0, "R5", "step two", {addr_oe, bus_req_n}, 0);
    @(negedge clk);
    check(bus_req_n === 1'b1, "R5", "request lifted", bus_req_n, 1);
    cmd_valid = 1; cmd_write = 1; @(negedge clk); cmd_valid = 0;
    check(err === 1'b1, "R7", "err while releasing", err, 1);
    repeat (3) @(negedge clk);
    bus_ack_n = 1;
    repeat (2) @(negedge clk);
    acq_req = 1; @(negedge clk); acq_req = 0;
    check(bus_req_n === 1'b0, "R5", "idle again, new request", bus_req_n, 0);
    check(nmi_n === 1'b1, "R1", "nmi_n inactive", nmi_n, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule